// File: doc/BRIEF.md
# Hebbian weight matrix builder

This block turns a small set of stored bipolar patterns into the symmetric weight matrix of a Hopfield-style associative memory. Each pattern arrives as a word of `NEURONS` bits, one bit per neuron: a 1 stands for the value +1 (ON) and a 0 for −1 (OFF). Up to `MAX_PAT` patterns are held. On a start pulse the block forms, for every neuron pair, the sum over the stored patterns of the product of the two neuron values, minus the pattern count on the diagonal. Subtracting the count makes every diagonal entry zero, and the matrix is symmetric, so only the strict upper triangle is produced.

An off-diagonal weight equals twice the number of patterns in which the two neuron bits agree, minus the pattern count M. With three patterns the weight is always one of −3, −1, +1 and +3. The block sends each weight as a 2-bit code on a valid/ready output stream, one pair per accepted transfer, and raises `done` when the last pair has been taken. Patterns come in on a valid/ready input stream. Both streams follow the usual rule: a transfer happens on a rising clock edge where valid and ready are both high. While `w_valid` is high and `w_ready` is low, the offered weight is held unchanged. `pat_ready` drops when the store is full or a build is running. `start`, `done` and `weight_err` are plain level signals.

Top module: `hebb_weight_builder`

## Requirements
- R1: A pattern is taken on a clock edge where `pat_valid` and `pat_ready` are both high. `pat_ready` is high only while no build is running and fewer than `MAX_PAT` patterns are held. Bit k of `pat_data` is neuron k, with 1 meaning +1 and 0 meaning −1.
- R2: `start` seen on an edge while idle makes `w_valid` high from the next cycle. Weights come out for pairs (i, j) with i < j in row-major order (i ascending, then j ascending), and `w_idx` counts 0, 1, … 35 in that order.
- R3: With three patterns held, the weight for (i, j) is W = 2·A − 3, where A is the number of patterns whose bits i and j are equal. `w_code` encodes W as 00 = −3, 01 = −1, 10 = +1, 11 = +3.
- R4: With one pattern held, a pair with equal bits gives +1 (code 10) and a pair with different bits gives −1 (code 01).
- R5: When 2·A − M is not one of −3, −1, +1, +3 (for example M = 0 or M = 2), the block sends code 00 for that pair and sets `weight_err`.
- R6: While `w_valid` is high and `w_ready` is low, `w_valid`, `w_idx` and `w_code` hold their values into the next cycle.
- R7: The edge that takes the last pair drops `w_valid` and raises `done`. `done` then stays high until the next start or the next accepted pattern. The store is emptied at that edge, so `pat_ready` is high again.
- R8: `weight_err` is sticky through a build, is cleared by the start that begins the next build, and stays low for builds in which every weight can be encoded.
- R9: During a build, `start` is ignored and no pattern is accepted. The stream carries exactly 36 weights.
- R10: After reset, `w_valid`, `done` and `weight_err` are low and `pat_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_valid | input | 1 | Pattern word offered |
| pat_ready | output | 1 | Block can take a pattern |
| pat_data | input | NEURONS | Pattern bits, 1 = +1, 0 = −1 |
| start | input | 1 | Begin a build from the held patterns |
| w_valid | output | 1 | Weight offered |
| w_ready | input | 1 | Consumer takes the weight |
| w_idx | output | IDX_W | Position of the pair in row-major upper-triangle order |
| w_code | output | 2 | Weight code, 00/01/10/11 = −3/−1/+1/+3 |
| done | output | 1 | All weights of the last build have been taken |
| weight_err | output | 1 | A weight of the current or last build could not be encoded |

## Verification
The bench builds the block with its default parameters, nine neurons and room for three patterns, which gives the full 36-pair stream. Under these defaults, loading zero to three patterns before a start exercises every pattern count: the encodable cases with one and three patterns, and the error cases with none and with two. Random back-pressure on `w_ready`, and pokes at `start` and `pat_valid` in the middle of a build, exercise the hold and ignore rules against a scoreboard fed from an independent model of the matrix.

// File: rtl/hebb_pkg.sv
package hebb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } hebb_state_e;

  localparam int unsigned WCODE_W = 2;
endpackage

// File: rtl/hebb_pat_store.sv
module hebb_pat_store #(
  parameter int unsigned NEURONS = 9,
  parameter int unsigned MAX_PAT = 3,
  parameter int unsigned CNT_W   = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [NEURONS-1:0]                wr_data,
  input  logic                              clr,
  output logic [MAX_PAT-1:0][NEURONS-1:0]   pats,
  output logic [CNT_W-1:0]                  count,
  output logic                              full
);

  logic [CNT_W-1:0] count_q;

  for (genvar s = 0; s < MAX_PAT; s++) begin : g_slot
    logic [NEURONS-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (wr_en && (count_q == CNT_W'(s))) begin
        slot_q <= wr_data;
      end
    end
    assign pats[s] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr) begin
      count_q <= '0;
    end else if (wr_en) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign count = count_q;
  assign full  = (count_q == CNT_W'(MAX_PAT));

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(MAX_PAT)); // R1
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full); // R1

endmodule

// File: rtl/hebb_pair_seq.sv
module hebb_pair_seq #(
  parameter int unsigned NEURONS = 9,
  parameter int unsigned POS_W   = 4,
  parameter int unsigned IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [POS_W-1:0] row,
  output logic [POS_W-1:0] col,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  logic [POS_W-1:0] row_q, col_q;
  logic [IDX_W-1:0] idx_q;
  logic             row_end;

  assign row_end = (col_q == POS_W'(NEURONS - 1));
  assign last    = row_end && (row_q == POS_W'(NEURONS - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= POS_W'(1);
      idx_q <= '0;
    end else if (restart) begin
      row_q <= '0;
      col_q <= POS_W'(1);
      idx_q <= '0;
    end else if (advance && !last) begin
      if (row_end) begin
        row_q <= row_q + POS_W'(1);
        col_q <= row_q + POS_W'(2);
      end else begin
        col_q <= col_q + POS_W'(1);
      end
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign row = row_q;
  assign col = col_q;
  assign idx = idx_q;

  AST_ROW_BELOW_COL: assert property (@(posedge clk) disable iff (!rst_n)
    row_q < col_q); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last && !restart) |=> (idx_q == $past(idx_q) + IDX_W'(1))); // R2
  AST_RESTART_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (idx_q == '0) && (row_q == '0)); // R2

endmodule

// File: rtl/hebb_weight_calc.sv
module hebb_weight_calc #(
  parameter int unsigned NEURONS = 9,
  parameter int unsigned MAX_PAT = 3,
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned POS_W   = 4
) (
  input  logic [MAX_PAT-1:0][NEURONS-1:0] pats,
  input  logic [CNT_W-1:0]                count,
  input  logic [POS_W-1:0]                row,
  input  logic [POS_W-1:0]                col,
  output logic [hebb_pkg::WCODE_W-1:0]    code,
  output logic                            unrep
);

  localparam int unsigned SW = $clog2(3 * MAX_PAT + 8) + 1;

  logic [MAX_PAT-1:0] agree_vec;
  logic [SW-1:0]      agree;
  logic [SW-1:0]      biased;
  logic [SW-1:0]      shifted;

  for (genvar p = 0; p < MAX_PAT; p++) begin : g_agree
    assign agree_vec[p] = (CNT_W'(p) < count) && (pats[p][row] == pats[p][col]);
  end

  always_comb begin
    agree = '0;
    for (int p = 0; p < MAX_PAT; p++) begin
      agree = agree + SW'(agree_vec[p]);
    end
    biased  = (agree << 1) + SW'(3) + SW'(MAX_PAT) - SW'(count);
    shifted = biased - SW'(MAX_PAT);
    unrep   = (shifted > SW'(6)) || shifted[0];
    code    = unrep ? '0 : shifted[2:1];
  end

endmodule

// File: rtl/hebb_weight_builder.sv
module hebb_weight_builder #(
  parameter  int unsigned NEURONS = 9,
  parameter  int unsigned MAX_PAT = 3,
  localparam int unsigned IDX_W   = $clog2(NEURONS * (NEURONS - 1) / 2)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           pat_valid,
  output logic                           pat_ready,
  input  logic [NEURONS-1:0]             pat_data,
  input  logic                           start,
  output logic                           w_valid,
  input  logic                           w_ready,
  output logic [IDX_W-1:0]               w_idx,
  output logic [hebb_pkg::WCODE_W-1:0]   w_code,
  output logic                           done,
  output logic                           weight_err
);
  import hebb_pkg::*;

  localparam int unsigned CNT_W = $clog2(MAX_PAT + 1);
  localparam int unsigned POS_W = $clog2(NEURONS);

  hebb_state_e state_q;
  logic [MAX_PAT-1:0][NEURONS-1:0] pats;
  logic [CNT_W-1:0] count;
  logic             full;
  logic [POS_W-1:0] row, col;
  logic             last;
  logic             unrep;
  logic             start_go, accept, emitting, xfer, finish;
  logic             done_q, err_q;

  assign emitting = (state_q == ST_EMIT);
  assign start_go = start && !emitting;
  assign pat_ready = !emitting && !full;
  assign accept   = pat_valid && pat_ready;
  assign xfer     = emitting && w_ready;
  assign finish   = xfer && last;

  hebb_pat_store #(
    .NEURONS(NEURONS), .MAX_PAT(MAX_PAT), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(pat_data),
    .clr(finish), .pats(pats), .count(count), .full(full)
  );

  hebb_pair_seq #(
    .NEURONS(NEURONS), .POS_W(POS_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(start_go), .advance(xfer),
    .row(row), .col(col), .idx(w_idx), .last(last)
  );

  hebb_weight_calc #(
    .NEURONS(NEURONS), .MAX_PAT(MAX_PAT), .CNT_W(CNT_W), .POS_W(POS_W)
  ) u_calc (
    .pats(pats), .count(count), .row(row), .col(col),
    .code(w_code), .unrep(unrep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_go) state_q <= ST_EMIT;
        ST_EMIT: if (finish)   state_q <= ST_IDLE;
        default:               state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (start_go || accept) begin
        done_q <= 1'b0;
      end else if (finish) begin
        done_q <= 1'b1;
      end
      if (start_go) begin
        err_q <= 1'b0;
      end else if (xfer && unrep) begin
        err_q <= 1'b1;
      end
    end
  end

  assign w_valid    = emitting;
  assign done       = done_q;
  assign weight_err = err_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && !w_ready) |=> (w_valid && $stable(w_idx) && $stable(w_code))); // R6
  AST_NO_LOAD_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> !pat_ready); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !w_valid); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !w_valid && pat_ready)); // R7
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !weight_err); // R8

endmodule

// File: tb/tb_hebb_weight_builder.sv
module tb_hebb_weight_builder;
  localparam int unsigned NEURONS = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pat_valid = 1'b0;
  logic pat_ready;
  logic [NEURONS-1:0] pat_data = '0;
  logic start = 1'b0;
  logic w_valid;
  logic w_ready = 1'b1;
  logic [5:0] w_idx;
  logic [1:0] w_code;
  logic done;
  logic weight_err;

  hebb_weight_builder dut (
    .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .pat_data(pat_data), .start(start), .w_valid(w_valid), .w_ready(w_ready),
    .w_idx(w_idx), .w_code(w_code), .done(done), .weight_err(weight_err)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  logic [NEURONS-1:0] pm[3];
  int m = 0;
  bit stall_en = 1'b0;
  bit exp_err;
  string cur_tag = "R3";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    w_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
  end

  // Monitor: hold rule and scoreboard compare
  bit stall_seen = 1'b0;
  logic [7:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_seen) begin
        check(w_valid && ({w_idx, w_code} == held), "R6 hold", int'({w_valid, w_idx, w_code}), int'({1'b1, held}));
      end
      stall_seen = w_valid && !w_ready;
      held = {w_idx, w_code};
      if (w_valid && w_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 extra weight", int'(w_idx), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check({w_idx, w_code} == e, {cur_tag, " R2 weight"}, int'({w_idx, w_code}), int'(e));
        end
      end
    end
  end

  function automatic logic [2:0] exp_w(int i, int j);
    int a = 0;
    int v;
    for (int p = 0; p < m; p++) if (pm[p][i] == pm[p][j]) a++;
    v = 2 * a - m;
    if (v == -3 || v == -1 || v == 1 || v == 3) return {1'b0, 2'((v + 3) / 2)};
    return 3'b100;
  endfunction

  task automatic load(input logic [NEURONS-1:0] d);
    @(posedge clk); #1;
    pat_valid = 1'b1;
    pat_data = d;
    @(negedge clk);
    while (!pat_ready) @(negedge clk);
    @(posedge clk); #1;
    pat_valid = 1'b0;
    pm[m] = d;
    m++;
  endtask

  task automatic run_build(input string tag, input bit stall, input bit poke);
    int k = 0;
    cur_tag = tag;
    exp_err = 1'b0;
    for (int i = 0; i < NEURONS - 1; i++) begin
      for (int j = i + 1; j < NEURONS; j++) begin
        logic [2:0] w;
        w = exp_w(i, j);
        exp_q.push_back({6'(k), w[1:0]});
        if (w[2]) exp_err = 1'b1;
        k++;
      end
    end
    stall_en = stall;
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(w_valid && w_idx == 6'd0, "R2 first weight", int'({w_valid, w_idx}), 64);
    check(!weight_err, "R8 cleared on start", int'(weight_err), 0);
    if (poke) begin
      repeat (8) @(posedge clk);
      #1;
      start = 1'b1;
      pat_valid = 1'b1;
      pat_data = 9'h155;
      @(negedge clk);
      check(!pat_ready, "R9 no load in build", int'(pat_ready), 0);
      @(posedge clk); #1;
      start = 1'b0;
      pat_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    stall_en = 1'b0;
    check(exp_q.size() == 0, "R9 all 36 sent", exp_q.size(), 0);
    check(!w_valid && pat_ready, "R7 idle after last", int'({w_valid, pat_ready}), 1);
    check(weight_err == exp_err, "R8 R5 err flag", int'(weight_err), int'(exp_err));
    m = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(pat_ready && !w_valid && !done && !weight_err, "R10 reset state",
          int'({pat_ready, w_valid, done, weight_err}), 8);

    // three patterns, no stalls
    load(9'b111_010_010);
    load(9'b111_100_111);
    load(9'b010_010_111);
    @(negedge clk);
    check(!pat_ready, "R1 store full", int'(pat_ready), 0);
    run_build("R3", 1'b0, 1'b0);
    check(done, "R7 done high", int'(done), 1);

    // one pattern: done drops on accept
    load(9'b101_001_110);
    @(negedge clk);
    check(!done, "R7 done cleared by load", int'(done), 0);
    run_build("R4", 1'b0, 1'b0);

    // two patterns: nothing encodable
    load(9'b000_111_010);
    load(9'b110_011_001);
    run_build("R5", 1'b0, 1'b0);
    check(weight_err, "R5 err set", int'(weight_err), 1);

    // no patterns
    run_build("R5", 1'b1, 1'b0);

    // three patterns with back-pressure and pokes during the build
    load(9'b011_101_100);
    load(9'b100_110_011);
    load(9'b111_000_101);
    run_build("R3 R6", 1'b1, 1'b1);

    // one more full build with stalls
    load(9'b001_001_001);
    load(9'b110_110_110);
    load(9'b010_101_010);
    run_build("R3 R6", 1'b1, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule